// File: doc/BRIEF.md
# Programmable External Interrupt Edge Detector

This block is the front end for six external interrupt pins. Each pin is brought into the clock domain through a two-stage synchronizer. The synchronized level is then compared with its value from the previous clock. A level change raises a single-cycle request on that channel's output, but only if the kind of change (rising or falling) is enabled for the channel.

Two 8-bit registers set the sensitivity. The rise-enable register sits at address 0xFF48 and the fall-enable register at 0xFF49. Bit n of each register belongs to channel n.

Software writes a register in one of two ways:
- A whole byte, using `byte_we` and `wdata`.
- One bit, set or cleared, using `bit_we`, `bit_idx` and `bit_set`.

`rd_data` returns the register selected by `bus_addr` at any time. Before a pin is handed over to another use, software clears both enable bits of its channel. This prevents a spurious request.

Top module: `pin_edge_irq`

## Requirements
- R1: After reset both enable registers read 0x00 and no request output is high.
- R2: A byte write to 0xFF48 loads the rise-enable register and a byte write to 0xFF49 loads the fall-enable register. `rd_data` shows the register addressed by `bus_addr`. Any other address reads 0x00, and a write to it changes neither register.
- R3: Bits 7 and 6 of both registers always read 0. Neither a byte write nor a bit operation can set them.
- R4: A bit operation changes only bit `bit_idx` of the addressed register: `bit_set`=1 sets it and `bit_set`=0 clears it. All other bits are unchanged.
- R5: Channel n takes the pair (rise bit n, fall bit n). The pair 00 gives no request, 01 gives falling edges only, 10 gives rising edges only, and 11 gives both.
- R6: A detected edge raises that channel's `irq_o` bit for exactly one cycle. The bit goes high after the third rising clock edge that follows the pin change.
- R7: While a channel is disabled, its level history keeps following the pin. Enabling the channel later, with the pin steady, gives no request.
- R8: If `byte_we` and `bit_we` are both high in the same cycle, the byte write wins.
- R9: Channels are independent: an edge on one pin raises only that channel's request.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| pins_i | input | 6 | External interrupt pins (asynchronous) |
| bus_addr | input | 16 | Register address for writes and readback |
| byte_we | input | 1 | Full-byte write strobe |
| wdata | input | 8 | Byte write data |
| bit_we | input | 1 | Single-bit operation strobe |
| bit_idx | input | 3 | Bit index for the bit operation |
| bit_set | input | 1 | 1 = set the bit, 0 = clear the bit |
| rd_data | output | 8 | Readback of the addressed register |
| irq_o | output | 6 | One-cycle request pulse per channel |

## Verification
A register write takes effect at the next rising clock edge. Readback is combinational, so the bench reads back one half-cycle after the write edge. A pin change made at a falling edge produces its request three rising edges later. The driver records the due cycle of each expected pulse in a scoreboard queue. The monitor compares `irq_o` against that queue on every falling edge, and expects zero on every cycle with no queued pulse, which also checks that each pulse ends after one cycle.

// File: rtl/pin_edge_irq.sv
module pin_edge_irq #(
  parameter int NCH = 6,
  parameter int DW = 8,
  parameter int AW = 16,
  parameter logic [AW-1:0] RISE_ADDR = 16'hFF48,
  parameter logic [AW-1:0] FALL_ADDR = 16'hFF49,
  localparam int IW = $clog2(DW)
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic [NCH-1:0] pins_i,
  input  logic [AW-1:0]  bus_addr,
  input  logic           byte_we,
  input  logic [DW-1:0]  wdata,
  input  logic           bit_we,
  input  logic [IW-1:0]  bit_idx,
  input  logic           bit_set,
  output logic [DW-1:0]  rd_data,
  output logic [NCH-1:0] irq_o
);

  logic [NCH-1:0] rise_q, fall_q;
  logic [NCH-1:0] s1, s2, prev, irq_q;
  logic [DW-1:0]  bmask;
  logic           sel_r, sel_f;

  assign sel_r = (bus_addr == RISE_ADDR);
  assign sel_f = (bus_addr == FALL_ADDR);
  assign bmask = DW'(1) << bit_idx;

  function automatic logic [NCH-1:0] upd(input logic [NCH-1:0] cur);
    if (byte_we)
      return wdata[NCH-1:0];
    else if (bit_set)
      return cur | bmask[NCH-1:0];
    else
      return cur & ~bmask[NCH-1:0];
  endfunction

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rise_q <= '0;
      fall_q <= '0;
    end else begin
      if (sel_r && (byte_we || bit_we)) rise_q <= upd(rise_q);
      if (sel_f && (byte_we || bit_we)) fall_q <= upd(fall_q);
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      s1    <= '0;
      s2    <= '0;
      prev  <= '0;
      irq_q <= '0;
    end else begin
      s1    <= pins_i;
      s2    <= s1;
      prev  <= s2;
      irq_q <= (s2 & ~prev & rise_q) | (~s2 & prev & fall_q);
    end
  end

  assign rd_data = sel_r ? DW'(rise_q) : (sel_f ? DW'(fall_q) : '0);
  assign irq_o   = irq_q;

endmodule

module pin_edge_irq_chk #(
  parameter int NCH = 6,
  parameter int DW = 8,
  parameter int AW = 16,
  parameter logic [AW-1:0] RISE_ADDR = 16'hFF48,
  parameter logic [AW-1:0] FALL_ADDR = 16'hFF49,
  localparam int IW = $clog2(DW)
) (
  input logic           clk,
  input logic           rst_n,
  input logic [AW-1:0]  bus_addr,
  input logic           byte_we,
  input logic [DW-1:0]  wdata,
  input logic           bit_we,
  input logic [IW-1:0]  bit_idx,
  input logic           bit_set,
  input logic [DW-1:0]  rd_data,
  input logic [NCH-1:0] irq_o,
  input logic [NCH-1:0] rise_q,
  input logic [NCH-1:0] fall_q,
  input logic [NCH-1:0] s2,
  input logic [NCH-1:0] prev
);

  AST_RESERVED_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    rd_data[DW-1:NCH] == '0); // R3

  AST_BYTE_WINS: assert property (@(posedge clk) disable iff (!rst_n)
    (byte_we && bus_addr == RISE_ADDR) |=> rise_q == $past(wdata[NCH-1:0])); // R8

  AST_BIT_SET: assert property (@(posedge clk) disable iff (!rst_n)
    (bit_we && !byte_we && bus_addr == FALL_ADDR && bit_set && int'(bit_idx) < NCH)
      |=> fall_q[$past(bit_idx)]); // R4

  AST_BIT_CLEAR: assert property (@(posedge clk) disable iff (!rst_n)
    (bit_we && !byte_we && bus_addr == RISE_ADDR && !bit_set && int'(bit_idx) < NCH)
      |=> !rise_q[$past(bit_idx)]); // R4

  AST_OFF_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
    (irq_o & ~$past(rise_q | fall_q)) == '0); // R5

  AST_EDGE_ONLY: assert property (@(posedge clk) disable iff (!rst_n)
    (irq_o & ~$past(s2 ^ prev)) == '0); // R6

endmodule

bind pin_edge_irq pin_edge_irq_chk #(
  .NCH(NCH), .DW(DW), .AW(AW), .RISE_ADDR(RISE_ADDR), .FALL_ADDR(FALL_ADDR)
) chk (
  .clk(clk), .rst_n(rst_n), .bus_addr(bus_addr), .byte_we(byte_we),
  .wdata(wdata), .bit_we(bit_we), .bit_idx(bit_idx), .bit_set(bit_set),
  .rd_data(rd_data), .irq_o(irq_o), .rise_q(rise_q), .fall_q(fall_q),
  .s2(s2), .prev(prev)
);

// File: tb/pin_edge_irq_test.sv
module pin_edge_irq_test;
  localparam logic [15:0] A_R = 16'hFF48;
  localparam logic [15:0] A_F = 16'hFF49;

  logic       clk = 0, rst_n = 0;
  logic [5:0] pins_i = '0;
  logic [15:0] bus_addr = '0;
  logic       byte_we = 0, bit_we = 0, bit_set = 0;
  logic [7:0] wdata = '0;
  logic [2:0] bit_idx = '0;
  logic [7:0] rd_data;
  logic [5:0] irq_o;

  int checks = 0, errors = 0, cyc = 0;
  bit done = 0;

  typedef struct { int due; logic [5:0] v; string tag; } item_t;
  item_t q[$];

  pin_edge_irq uut (.*);

  always #5 clk = ~clk;
  always @(posedge clk) cyc <= cyc + 1;

  always @(negedge clk) begin
    if (rst_n && !done) begin
      logic [5:0] e;
      string t;
      e = '0; t = "R6";
      if (q.size() > 0 && q[0].due == cyc) begin
        e = q[0].v; t = q[0].tag; void'(q.pop_front());
      end
      checks++;
      if (irq_o !== e) begin
        errors++;
        $display("FAIL %s cycle %0d irq_o actual %b expected %b", t, cyc, irq_o, e);
      end
    end
  end

  task automatic bwrite(input logic [15:0] a, input logic [7:0] d);
    @(negedge clk); bus_addr = a; wdata = d; byte_we = 1;
    @(negedge clk); byte_we = 0;
  endtask

  task automatic bitop(input logic [15:0] a, input int idx, input logic s);
    @(negedge clk); bus_addr = a; bit_idx = 3'(idx); bit_set = s; bit_we = 1;
    @(negedge clk); bit_we = 0;
  endtask

  task automatic rd(input logic [15:0] a, input logic [7:0] e, input string tag);
    bus_addr = a; #1;
    checks++;
    if (rd_data !== e) begin
      errors++;
      $display("FAIL %s readback %h actual %h expected %h", tag, a, rd_data, e);
    end
  endtask

  task automatic pins(input logic [5:0] v, input logic [5:0] e, input string tag);
    @(negedge clk); pins_i = v;
    q.push_back('{cyc + 3, e, tag});
    repeat (6) @(negedge clk);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    errors++;
    $display("FAIL watchdog expired");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    rd(A_R, 8'h00, "R1");
    rd(A_F, 8'h00, "R1");

    bwrite(A_R, 8'hFF);
    rd(A_R, 8'h3F, "R3");
    bwrite(16'hFF4A, 8'hAA);
    rd(A_R, 8'h3F, "R2");
    rd(A_F, 8'h00, "R2");
    rd(16'hFF4A, 8'h00, "R2");
    bitop(A_R, 0, 0);
    bitop(A_R, 1, 0);
    rd(A_R, 8'h3C, "R4");
    bitop(A_R, 7, 1);
    rd(A_R, 8'h3C, "R3");
    bitop(A_F, 1, 1);
    bitop(A_F, 3, 1);
    bitop(A_F, 5, 1);
    bitop(A_F, 6, 0);
    rd(A_F, 8'h2A, "R4");
    rd(A_R, 8'h3C, "R4");

    @(negedge clk); bus_addr = A_F; wdata = 8'hFF; byte_we = 1;
    bit_we = 1; bit_idx = 3'd2; bit_set = 0;
    @(negedge clk); byte_we = 0; bit_we = 0;
    rd(A_F, 8'h3F, "R8");
    bwrite(A_F, 8'h2A);
    rd(A_F, 8'h2A, "R2");

    pins(6'b111111, 6'h3C, "R5");
    pins(6'b000000, 6'h2A, "R5");
    pins(6'b010000, 6'h10, "R9");
    pins(6'b000000, 6'h00, "R5");
    pins(6'b001000, 6'h08, "R9");
    pins(6'b000000, 6'h08, "R5");

    pins(6'b000001, 6'h00, "R7");
    bitop(A_R, 0, 1);
    repeat (5) @(negedge clk);
    pins(6'b000000, 6'h00, "R7");
    pins(6'b000001, 6'h01, "R7");
    bitop(A_R, 0, 0);
    pins(6'b000000, 6'h00, "R5");

    repeat (5) @(negedge clk);
    done = 1;
    checks++;
    if (q.size() != 0) begin
      errors++;
      $display("FAIL R6 pending items actual %0d expected 0", q.size());
    end
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule